// File: doc/BRIEF.md
# CCD Electronic Shutter Controller

This block sets the exposure of a progressive-scan CCD sensor. It drives two line-rate pulse outputs. The discharge pulse `xsub` clears the photosites. The readout pulse `xsg` moves the collected charge into the vertical register. The line and field boundaries arrive as single-cycle ticks from an external sync generator. The shutter setting is a 2-bit mode and a 9-bit load value. It comes either from a fixed preset table addressed by pins, or from a 12-bit serial word that is shifted in on a clock line and takes effect on a strobe.

Four modes are supported. In fast mode the exposure is a number of lines derived from the load value. Flickerless mode uses a fixed exposure of about 1/100 s. Slow mode reads out once every even number of fields. In the off mode the sensor is read once per field and never discharged. A separate trigger mode keeps discharging the sensor on every line until an external trigger falls. At that point the block asks the sync generator to restart line timing, discharges the sensor once more, waits out the programmed exposure, and then issues readout together with a write-enable pulse. While trigger mode is active, the block tells the sync generator to hold its vertical outputs.

Top module: `exposure_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `xsub`, `xsg`, `wen`, `line_rst`, `vsync_hold` and `cfg_err` are all low.
- R2: The mode code {m1,m0} means: 00 flickerless, 01 fast, 10 slow, 11 off. With `sel_serial` low in fast mode, `pin_code` 0..7 selects the load values 0x196, 0x176, 0x137, 0x118, 0x108, 0x100, 0x0FC, 0x0FA. The exposure is E = L − 249 lines, with a minimum of 1. Per field of 262 lines, `xsub` pulses once on each of lines 0 to 261−E, and `xsg` pulses once at every field tick.
- R3: In flickerless mode, E is fixed at 157 lines, so there are 105 `xsub` pulses per field and one `xsg` per field.
- R4: In off mode there is no `xsub` pulse, and `xsg` pulses once per field.
- R5: In slow mode there is no `xsub` pulse, and `xsg` pulses once every N = 2·(511 − L) fields. With parallel setting, `pin_code` k selects L = 0x1FE − k, which gives N = 2·(k+1).
- R6: With `sel_serial` high, a word is shifted in LSB first on rising edges of `ser_clk`. Bits 0..8 are the load value, bit 9 is m1, bit 10 is m0, and bit 11 is ignored. The word takes effect on the rising edge of `ser_stb`, and the mode pins are then ignored.
- R7: A serial word that selects slow mode with load 0x0FF is rejected. The previous setting stays in force, and `cfg_err` goes high and stays high until reset.
- R8: In trigger mode (`rand_mode` high) before a trigger, `xsub` pulses on every line tick and `xsg` stays low.
- R9: On a falling edge of `trig` in trigger mode, `line_rst` and `xsub` each pulse exactly once. `xsub` then stays low. On the E-th line tick after the trigger, `xsg` and `wen` pulse together in the same cycle, and the block returns to per-line discharge. In slow and off modes, E is 262 lines.
- R10: `vsync_hold` follows `rand_mode` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle pulse at each line start |
| field_tick | input | 1 | One-cycle pulse at field start, coincident with a line tick |
| sel_serial | input | 1 | 0: preset setting from pins, 1: serial word |
| pin_mode | input | 2 | Mode code {m1,m0} for the pin setting |
| pin_code | input | 3 | Preset index for the pin setting |
| ser_stb | input | 1 | Serial strobe; the word takes effect on its rising edge |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| rand_mode | input | 1 | Trigger mode enable |
| trig | input | 1 | External exposure trigger; acts on its falling edge |
| xsub | output | 1 | Sensor discharge pulse |
| xsg | output | 1 | Readout pulse |
| wen | output | 1 | Frame-store write enable, trigger mode only |
| line_rst | output | 1 | Request to restart line timing |
| vsync_hold | output | 1 | Hold vertical sync outputs |
| cfg_err | output | 1 | Sticky flag for a rejected setting |

## Verification
Pin settings take effect one cycle after they change, and the discharge and readout pulses appear one cycle after the tick that causes them. For these modes the bench settles for 20 cycles and then counts pulses over a window that spans exactly a whole number of field periods, so the phase of the window cannot change the count. Serial inputs pass three synchronizer stages, and every serial bit is held for several cycles. A trigger fall produces `line_rst` three cycles later. The bench therefore releases the trigger just after a line tick. It skips two cycles before counting discharges, and it counts line ticks up to the cycle in which `xsg` is seen, expecting exactly E of them.

// File: rtl/exp_pkg.sv
package exp_pkg;
  typedef enum logic [1:0] {
    M_FLK  = 2'b00,
    M_FAST = 2'b01,
    M_SLOW = 2'b10,
    M_OFF  = 2'b11
  } shut_mode_t;

  typedef struct packed {
    shut_mode_t  mode;
    logic [8:0]  load;
  } shut_cfg_t;

  // preset load value chosen by the pin code for a given mode
  function automatic logic [8:0] preset_load(input shut_mode_t m, input logic [2:0] c);
    logic [8:0] r;
    r = 9'h196;
    if (m == M_FAST) begin
      case (c)
        3'd0:    r = 9'h196;
        3'd1:    r = 9'h176;
        3'd2:    r = 9'h137;
        3'd3:    r = 9'h118;
        3'd4:    r = 9'h108;
        3'd5:    r = 9'h100;
        3'd6:    r = 9'h0FC;
        default: r = 9'h0FA;
      endcase
    end else if (m == M_SLOW) begin
      r = 9'h1FE - {6'd0, c};
    end
    return r;
  endfunction
endpackage

// File: rtl/serial_loader.sv
module serial_loader #(
  parameter int WORD_BITS = 12,
  parameter int SYNC_STAGES = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic                 sclk,
  input  logic                 sdat,
  output logic [WORD_BITS-1:0] word,
  output logic                 word_stb
);
  logic [SYNC_STAGES-1:0] s_stb, s_clk, s_dat;
  logic [WORD_BITS-1:0]   shreg;
  logic                   clk_rise, stb_rise;

  assign clk_rise = s_clk[SYNC_STAGES-2] & ~s_clk[SYNC_STAGES-1];
  assign stb_rise = s_stb[SYNC_STAGES-2] & ~s_stb[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      s_stb    <= '0;
      s_clk    <= '0;
      s_dat    <= '0;
      shreg    <= '0;
      word     <= '0;
      word_stb <= 1'b0;
    end else begin
      s_stb    <= {s_stb[SYNC_STAGES-2:0], stb};
      s_clk    <= {s_clk[SYNC_STAGES-2:0], sclk};
      s_dat    <= {s_dat[SYNC_STAGES-2:0], sdat};
      word_stb <= stb_rise;
      if (clk_rise) shreg <= {s_dat[SYNC_STAGES-2], shreg[WORD_BITS-1:1]};
      if (stb_rise) word <= shreg;
    end
  end
endmodule

// File: rtl/shutter_cfg.sv
module shutter_cfg
  import exp_pkg::*;
#(
  parameter int WORD_BITS = 12,
  parameter int LOAD_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_serial,
  input  logic [1:0]           pin_mode,
  input  logic [2:0]           pin_code,
  input  logic [WORD_BITS-1:0] word,
  input  logic                 word_stb,
  output shut_cfg_t            cfg,
  output logic                 err
);
  localparam logic [LOAD_BITS-1:0] BAD_SLOW = LOAD_BITS'(9'h0FF);

  shut_mode_t           w_mode, p_mode;
  logic [LOAD_BITS-1:0] w_load;

  assign w_load = word[LOAD_BITS-1:0];
  assign w_mode = shut_mode_t'({word[LOAD_BITS], word[LOAD_BITS+1]});
  assign p_mode = shut_mode_t'(pin_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.mode <= M_OFF;
      cfg.load <= 9'h1FF;
      err      <= 1'b0;
    end else if (!sel_serial) begin
      cfg.mode <= p_mode;
      cfg.load <= preset_load(p_mode, pin_code);
    end else if (word_stb) begin
      if (w_mode == M_SLOW && w_load == BAD_SLOW) begin
        err <= 1'b1;
      end else begin
        cfg.mode <= w_mode;
        cfg.load <= w_load;
      end
    end
  end
endmodule

// File: rtl/exposure_timer.sv
module exposure_timer
  import exp_pkg::*;
#(
  parameter int FIELD_LINES = 262,
  parameter int FLK_LINES   = 157,
  parameter int LOAD_MAX    = 511
) (
  input  logic      clk,
  input  logic      rst,
  input  shut_cfg_t cfg,
  input  logic      line_tick,
  input  logic      field_tick,
  input  logic      rand_mode,
  input  logic      trig,
  output logic      xsub,
  output logic      xsg,
  output logic      wen,
  output logic      line_rst,
  output logic      vsync_hold
);
  localparam int OFFS = LOAD_MAX - FIELD_LINES;

  logic [2:0]  t_s;
  logic        trig_fall, busy;
  logic [9:0]  exp_lines, sub_lim, line_idx, nxt_idx, tcnt, ld_ext;
  logic [10:0] slow_n, fcnt;
  logic        xsub_n, xsg_n, lrst_n;

  assign trig_fall = t_s[2] & ~t_s[1];
  assign ld_ext    = {1'b0, cfg.load};

  always_comb begin
    case (cfg.mode)
      M_FAST:  exp_lines = (ld_ext <= 10'(OFFS)) ? 10'd1 : ld_ext - 10'(OFFS);
      M_FLK:   exp_lines = 10'(FLK_LINES);
      default: exp_lines = 10'(FIELD_LINES);
    endcase
    slow_n  = {10'(LOAD_MAX) - ld_ext, 1'b0};
    sub_lim = 10'(FIELD_LINES) - exp_lines;
    nxt_idx = field_tick ? 10'd0 : line_idx + 10'd1;
    xsub_n  = 1'b0;
    xsg_n   = 1'b0;
    lrst_n  = 1'b0;
    if (rand_mode) begin
      if (!busy) begin
        xsub_n = line_tick;
        if (trig_fall) begin
          xsub_n = 1'b1;
          lrst_n = 1'b1;
        end
      end else if (line_tick && (tcnt + 10'd1 >= exp_lines)) begin
        xsg_n = 1'b1;
      end
    end else begin
      xsub_n = line_tick && (cfg.mode == M_FAST || cfg.mode == M_FLK) && (nxt_idx < sub_lim);
      if (field_tick) xsg_n = (cfg.mode != M_SLOW) || (fcnt + 11'd1 >= slow_n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_s        <= '0;
      busy       <= 1'b0;
      tcnt       <= '0;
      line_idx   <= '0;
      fcnt       <= '0;
      xsub       <= 1'b0;
      xsg        <= 1'b0;
      wen        <= 1'b0;
      line_rst   <= 1'b0;
      vsync_hold <= 1'b0;
    end else begin
      t_s <= {t_s[1:0], trig};
      if (field_tick)     line_idx <= '0;
      else if (line_tick) line_idx <= line_idx + 10'd1;
      if (!rand_mode) begin
        busy <= 1'b0;
      end else if (!busy && trig_fall) begin
        busy <= 1'b1;
        tcnt <= '0;
      end else if (busy && line_tick) begin
        if (xsg_n) busy <= 1'b0;
        tcnt <= tcnt + 10'd1;
      end
      if (rand_mode || cfg.mode != M_SLOW) fcnt <= '0;
      else if (field_tick)                 fcnt <= xsg_n ? 11'd0 : fcnt + 11'd1;
      xsub       <= xsub_n;
      xsg        <= xsg_n;
      wen        <= xsg_n & rand_mode;
      line_rst   <= lrst_n;
      vsync_hold <= rand_mode;
    end
  end
endmodule

// File: rtl/exposure_ctrl.sv
module exposure_ctrl
  import exp_pkg::*;
#(
  parameter int FIELD_LINES = 262,
  parameter int FLK_LINES   = 157,
  parameter int LOAD_BITS   = 9,
  parameter int WORD_BITS   = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_tick,
  input  logic       field_tick,
  input  logic       sel_serial,
  input  logic [1:0] pin_mode,
  input  logic [2:0] pin_code,
  input  logic       ser_stb,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       rand_mode,
  input  logic       trig,
  output logic       xsub,
  output logic       xsg,
  output logic       wen,
  output logic       line_rst,
  output logic       vsync_hold,
  output logic       cfg_err
);
  localparam int LOAD_MAX = (1 << LOAD_BITS) - 1;

  logic [WORD_BITS-1:0] ser_word;
  logic                 ser_take;
  shut_cfg_t            cfg_q;

  serial_loader #(.WORD_BITS(WORD_BITS), .SYNC_STAGES(3)) u_ser (
    .clk(clk), .rst(rst), .stb(ser_stb), .sclk(ser_clk), .sdat(ser_dat),
    .word(ser_word), .word_stb(ser_take)
  );

  shutter_cfg #(.WORD_BITS(WORD_BITS), .LOAD_BITS(LOAD_BITS)) u_cfg (
    .clk(clk), .rst(rst), .sel_serial(sel_serial), .pin_mode(pin_mode),
    .pin_code(pin_code), .word(ser_word), .word_stb(ser_take),
    .cfg(cfg_q), .err(cfg_err)
  );

  exposure_timer #(.FIELD_LINES(FIELD_LINES), .FLK_LINES(FLK_LINES), .LOAD_MAX(LOAD_MAX)) u_tmr (
    .clk(clk), .rst(rst), .cfg(cfg_q), .line_tick(line_tick), .field_tick(field_tick),
    .rand_mode(rand_mode), .trig(trig), .xsub(xsub), .xsg(xsg), .wen(wen),
    .line_rst(line_rst), .vsync_hold(vsync_hold)
  );
endmodule

// File: rtl/exposure_ctrl_chk.sv
module exposure_ctrl_chk
  import exp_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      rand_mode,
  input logic      line_tick,
  input logic      xsub,
  input logic      xsg,
  input logic      wen,
  input logic      cfg_err,
  input logic      vsync_hold,
  input shut_cfg_t cfg
);
  AST_WEN_WITH_XSG: assert property (@(posedge clk) disable iff (rst) wen |-> xsg); // R9
  AST_XSG_SINGLE: assert property (@(posedge clk) disable iff (rst) xsg |=> !xsg); // R4
  AST_NO_XSUB_SLOW: assert property (@(posedge clk) disable iff (rst)
    $past(!rand_mode && (cfg.mode == M_SLOW || cfg.mode == M_OFF)) |-> !xsub); // R5
  AST_XSUB_ON_LINE: assert property (@(posedge clk) disable iff (rst)
    xsub |-> ($past(line_tick) || $past(rand_mode))); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) $past(cfg_err) |-> cfg_err); // R7
  AST_NO_BAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(cfg.mode == M_SLOW && cfg.load == 9'h0FF)); // R7
  AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (vsync_hold == $past(rand_mode))); // R10
endmodule

bind exposure_ctrl exposure_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .rand_mode(rand_mode), .line_tick(line_tick), .xsub(xsub),
  .xsg(xsg), .wen(wen), .cfg_err(cfg_err), .vsync_hold(vsync_hold), .cfg(cfg_q)
);

// File: tb/tb_exposure_ctrl.sv
module tb_exposure_ctrl;
  localparam int LP = 6;
  localparam int FL = 262;
  localparam int WIN = 8 * FL * LP;

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  code;
    logic [11:0] nsub;
    logic [3:0]  nsg;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b01, 3'd0, 12'd840,  4'd8, 4'd2},  // R2 L=0x196 E=157
    '{2'b01, 3'd2, 12'd1600, 4'd8, 4'd2},  // R2 L=0x137 E=62
    '{2'b01, 3'd7, 12'd2088, 4'd8, 4'd2},  // R2 L=0x0FA E=1
    '{2'b01, 3'd5, 12'd2040, 4'd8, 4'd2},  // R2 L=0x100 E=7
    '{2'b00, 3'd0, 12'd840,  4'd8, 4'd3},  // R3 flickerless
    '{2'b11, 3'd0, 12'd0,    4'd8, 4'd4},  // R4 off
    '{2'b10, 3'd0, 12'd0,    4'd4, 4'd5},  // R5 N=2
    '{2'b10, 3'd3, 12'd0,    4'd1, 4'd5}   // R5 N=8
  };

  logic clk = 1'b0, rst = 1'b1;
  logic line_tick, field_tick;
  logic sel_serial = 1'b0, ser_stb = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [1:0] pin_mode = 2'b11;
  logic [2:0] pin_code = 3'd0;
  logic rand_mode = 1'b0, trig = 1'b0;
  logic xsub, xsg, wen, line_rst, vsync_hold, cfg_err;
  int lc, ln;
  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      lc <= 0; ln <= 0; line_tick <= 1'b0; field_tick <= 1'b0;
    end else begin
      lc <= (lc == LP - 1) ? 0 : lc + 1;
      if (lc == LP - 1) ln <= (ln == FL - 1) ? 0 : ln + 1;
      line_tick  <= (lc == LP - 1);
      field_tick <= (lc == LP - 1) && (ln == FL - 1);
    end
  end

  exposure_ctrl dut (
    .clk(clk), .rst(rst), .line_tick(line_tick), .field_tick(field_tick),
    .sel_serial(sel_serial), .pin_mode(pin_mode), .pin_code(pin_code),
    .ser_stb(ser_stb), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .rand_mode(rand_mode), .trig(trig), .xsub(xsub), .xsg(xsg), .wen(wen),
    .line_rst(line_rst), .vsync_hold(vsync_hold), .cfg_err(cfg_err)
  );

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int ncyc, output int nsub, output int nsg);
    nsub = 0; nsg = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      nsub += int'(xsub);
      nsg  += int'(xsg);
    end
  endtask

  task automatic send_word(input logic [11:0] w);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); ser_dat = w[i];
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (3) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk); ser_stb = 1'b1;
    repeat (4) @(negedge clk); ser_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int ns, ng, ticks, nrst, nwen;
    bit same;
    // R1 reset state
    repeat (4) @(negedge clk);
    check({xsub, xsg, wen, line_rst, vsync_hold, cfg_err} == 6'b0, "R1", int'({xsub, xsg, wen, line_rst, vsync_hold, cfg_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({xsub, xsg, wen, line_rst, vsync_hold, cfg_err} == 6'b0, "R1", int'({xsub, xsg, wen, line_rst, vsync_hold, cfg_err}), 0);

    // table of parallel settings
    foreach (VECS[k]) begin
      pin_mode = VECS[k].mode;
      pin_code = VECS[k].code;
      repeat (20) @(negedge clk);
      measure(WIN, ns, ng);
      check(ns == int'(VECS[k].nsub), rname(VECS[k].req), ns, int'(VECS[k].nsub));
      check(ng == int'(VECS[k].nsg), rname(VECS[k].req), ng, int'(VECS[k].nsg));
    end

    // R6 serial slow word, pins say fast code 7
    pin_mode = 2'b01; pin_code = 3'd7; sel_serial = 1'b1;
    send_word({1'b0, 1'b0, 1'b1, 9'h1FE});
    measure(WIN, ns, ng);
    check(ns == 0, "R6", ns, 0);
    check(ng == 4, "R6", ng, 4);
    // R7 illegal slow load rejected
    send_word({1'b0, 1'b0, 1'b1, 9'h0FF});
    check(cfg_err == 1'b1, "R7", int'(cfg_err), 1);
    measure(WIN, ns, ng);
    check(ng == 4, "R7", ng, 4);
    check(ns == 0, "R7", ns, 0);
    // R6 serial fast word L=0x10A -> E=17, 245 discharges per field
    send_word({1'b0, 1'b1, 1'b0, 9'h10A});
    measure(2 * FL * LP, ns, ng);
    check(ns == 490, "R6", ns, 490);
    check(ng == 2, "R6", ng, 2);
    check(cfg_err == 1'b1, "R7", int'(cfg_err), 1);

    // trigger mode, parallel fast code 2 -> E=62
    sel_serial = 1'b0; pin_mode = 2'b01; pin_code = 3'd2;
    @(negedge clk); rand_mode = 1'b1;
    repeat (2) @(negedge clk);
    check(vsync_hold == 1'b1, "R10", int'(vsync_hold), 1);
    repeat (20) @(negedge clk);
    measure(10 * LP, ns, ng);
    check(ns == 10, "R8", ns, 10);
    check(ng == 0, "R8", ng, 0);
    trig = 1'b1;
    repeat (10) @(negedge clk);
    while (line_tick !== 1'b1) @(negedge clk);
    trig = 1'b0;
    repeat (2) @(negedge clk);
    ns = 0; ticks = 0; nrst = 0; nwen = 0; same = 1'b0;
    for (int i = 0; i < 62 * LP + 100; i++) begin
      @(negedge clk);
      if (xsg) begin
        same = wen;
        break;
      end
      ns += int'(xsub); ticks += int'(line_tick); nrst += int'(line_rst); nwen += int'(wen);
    end
    check(ticks == 62, "R9", ticks, 62);
    check(ns == 1, "R9", ns, 1);
    check(nrst == 1, "R9", nrst, 1);
    check(same && nwen == 0, "R9", int'(same), 1);
    measure(10 * LP, ns, ng);
    check(ns == 10, "R8", ns, 10);
    check(ng == 0, "R8", ng, 0);
    rand_mode = 1'b0;
    repeat (2) @(negedge clk);
    check(vsync_hold == 1'b0, "R10", int'(vsync_hold), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule